// File: doc/BRIEF.md
# Counter-Rotating Ring Interconnect for Memory Traffic

The block carries request and response packets between stops on two rings that turn in opposite directions, one clockwise (stop i to stop i+1) and one counter-clockwise (stop i to stop i-1). There are `N_STOPS` stops, five by default. Stops 0 to `N_STOPS-2` are full stops, each serving a memory channel. The last stop is a reduced stop for the host and peripheral port. Each stop has an inject port and an eject port, both valid-ready. An injected packet carries a destination stop, a tag and one 32-bit channel word. The stop adds its own index as the source.

The injecting stop picks the ring for each packet so that the packet takes the fewest hops. The packet then moves one stop per clock and leaves at its destination. A memory client that sends a response addresses it to the `ej_src_o` it received and reuses the same tag. The requester can then match the response to its request.

Traffic already on a ring always has priority over a new injection. A packet that cannot leave at its destination stays on its ring and comes back around.

Top module: `bidir_ring`

## Requirements
- R1: For a packet injected at stop s with destination d, the clockwise hop count is h = (d - s) mod N_STOPS. The packet takes the clockwise ring when 2*h <= N_STOPS, so ties go clockwise, and the counter-clockwise ring otherwise.
- R2: Each hop takes one clock. On idle rings, a packet accepted in cycle c shows `ej_valid_o` at its destination in cycle c + hops. A packet addressed to its own stop takes a full clockwise lap of N_STOPS cycles.
- R3: At a stop, `inj_ready_o` is high exactly when the slot arriving on the chosen ring is empty, or is freed as described in R4. When both arriving slots are empty, the stop is always ready.
- R4: At a full stop, a packet that leaves at this stop in the current cycle frees its ring slot, and a new packet may be injected into that slot in the same cycle.
- R5: The host stop (index N_STOPS-1) never reuses a slot freed in the same cycle. It is ready only when the arriving slot on the chosen ring is empty.
- R6: When both rings bring a packet for the same stop in the same cycle, the clockwise packet leaves. The counter-clockwise packet continues on its ring.
- R7: A packet at its destination while `ej_ready_i` is low stays on its ring and is offered again N_STOPS cycles later.
- R8: An ejected packet presents the injecting stop's index on `ej_src_o`, together with the tag and the 32-bit word it was injected with, all unchanged.
- R9: After reset both rings are empty: no eject is valid and every stop is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inj_valid_i | input | N_STOPS | Inject request, one bit per stop |
| inj_ready_o | output | N_STOPS | Inject accepted, one bit per stop |
| inj_dst_i | input | N_STOPS x STOP_W | Destination stop index, must be below N_STOPS |
| inj_tag_i | input | N_STOPS x TAG_W | Request tag |
| inj_data_i | input | N_STOPS x DATA_W | 32-bit channel word |
| ej_valid_o | output | N_STOPS | Packet present at its destination |
| ej_ready_i | input | N_STOPS | Stop takes the presented packet |
| ej_src_o | output | N_STOPS x STOP_W | Index of the injecting stop |
| ej_tag_o | output | N_STOPS x TAG_W | Tag of the presented packet |
| ej_data_o | output | N_STOPS x DATA_W | Word of the presented packet |

## Verification
`inj_ready_o` depends on the arriving slots and on the inject destination in the same cycle. It is therefore compared in the cycle its inputs are driven. An accepted packet enters a ring register at the next edge and reaches its destination's eject port exactly one cycle per hop later. A deflected packet reappears N_STOPS cycles after it was refused.

The bench drives inputs at the falling edge and compares outputs shortly after. It advances its reference model once per cycle. The directed checks compare the logged eject cycle against the acceptance cycle plus the expected hop count: 2, 5 or 7 cycles depending on the case.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int STOP_W = 3;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic              vld;
    logic [STOP_W-1:0] dst;
    logic [STOP_W-1:0] src;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } pkt_t;
endpackage

// File: rtl/ring_route.sv
module ring_route import ring_pkg::*; #(
  parameter int N_STOPS = 5,
  parameter int ID      = 0
) (
  input  logic [STOP_W-1:0] dst_i,
  output logic              use_ccw_o
);
  localparam int unsigned NS  = N_STOPS;
  localparam int unsigned OFS = N_STOPS - ID;

  int unsigned cw_hops;

  always_comb begin
    cw_hops   = (32'(dst_i) + OFS) % NS;
    use_ccw_o = (2 * cw_hops) > NS;  // tie stays clockwise
  end
endmodule

// File: rtl/ring_stop.sv
module ring_stop import ring_pkg::*; #(
  parameter int N_STOPS = 5,
  parameter int ID      = 0,
  parameter bit LITE    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pkt_t              cw_i,
  input  pkt_t              ccw_i,
  output pkt_t              cw_o,
  output pkt_t              ccw_o,
  input  logic              inj_valid_i,
  output logic              inj_ready_o,
  input  logic [STOP_W-1:0] inj_dst_i,
  input  logic [TAG_W-1:0]  inj_tag_i,
  input  logic [DATA_W-1:0] inj_data_i,
  output logic              ej_valid_o,
  input  logic              ej_ready_i,
  output logic [STOP_W-1:0] ej_src_o,
  output logic [TAG_W-1:0]  ej_tag_o,
  output logic [DATA_W-1:0] ej_data_o
);
  localparam logic [STOP_W-1:0] MY_ID = STOP_W'(ID);

  logic use_ccw, hit_cw, hit_ccw, take_cw, take_ccw;
  logic free_cw, free_ccw, fire;
  pkt_t inj_pkt, cw_d, ccw_d;

  ring_route #(.N_STOPS(N_STOPS), .ID(ID)) u_route (
    .dst_i    (inj_dst_i),
    .use_ccw_o(use_ccw)
  );

  always_comb begin
    hit_cw     = cw_i.vld && (cw_i.dst == MY_ID);
    hit_ccw    = ccw_i.vld && (ccw_i.dst == MY_ID);
    take_cw    = hit_cw && ej_ready_i;
    take_ccw   = hit_ccw && !hit_cw && ej_ready_i;  // clockwise wins the port
    ej_valid_o = hit_cw || hit_ccw;
    ej_src_o   = hit_cw ? cw_i.src  : ccw_i.src;
    ej_tag_o   = hit_cw ? cw_i.tag  : ccw_i.tag;
    ej_data_o  = hit_cw ? cw_i.data : ccw_i.data;
  end

  // reduced stop: no same-cycle slot reuse
  if (LITE) begin : g_lite
    assign free_cw  = !cw_i.vld;
    assign free_ccw = !ccw_i.vld;
  end else begin : g_full
    assign free_cw  = !cw_i.vld || take_cw;
    assign free_ccw = !ccw_i.vld || take_ccw;
  end

  always_comb begin
    inj_ready_o = use_ccw ? free_ccw : free_cw;
    fire        = inj_valid_i && inj_ready_o;
    inj_pkt     = '{vld: 1'b1, dst: inj_dst_i, src: MY_ID, tag: inj_tag_i, data: inj_data_i};

    if (fire && !use_ccw) cw_d = inj_pkt;
    else if (take_cw)     cw_d = '0;
    else                  cw_d = cw_i;

    if (fire && use_ccw)  ccw_d = inj_pkt;
    else if (take_ccw)    ccw_d = '0;
    else                  ccw_d = ccw_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cw_o  <= '0;
      ccw_o <= '0;
    end else begin
      cw_o  <= cw_d;
      ccw_o <= ccw_d;
    end
  end
endmodule

// File: rtl/bidir_ring.sv
module bidir_ring import ring_pkg::*; #(
  parameter int N_STOPS = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_STOPS-1:0]               inj_valid_i,
  output logic [N_STOPS-1:0]               inj_ready_o,
  input  logic [N_STOPS-1:0][STOP_W-1:0]   inj_dst_i,
  input  logic [N_STOPS-1:0][TAG_W-1:0]    inj_tag_i,
  input  logic [N_STOPS-1:0][DATA_W-1:0]   inj_data_i,
  output logic [N_STOPS-1:0]               ej_valid_o,
  input  logic [N_STOPS-1:0]               ej_ready_i,
  output logic [N_STOPS-1:0][STOP_W-1:0]   ej_src_o,
  output logic [N_STOPS-1:0][TAG_W-1:0]    ej_tag_o,
  output logic [N_STOPS-1:0][DATA_W-1:0]   ej_data_o
);
  localparam int HOST_ID = N_STOPS - 1;

  pkt_t cw_q  [N_STOPS];
  pkt_t ccw_q [N_STOPS];
  logic [N_STOPS-1:0] cw_vld, ccw_vld;

  for (genvar i = 0; i < N_STOPS; i++) begin : g_stop
    localparam int PRV = (i + N_STOPS - 1) % N_STOPS;
    localparam int NXT = (i + 1) % N_STOPS;

    ring_stop #(.N_STOPS(N_STOPS), .ID(i), .LITE(i == HOST_ID)) u_stop (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cw_i       (cw_q[PRV]),
      .ccw_i      (ccw_q[NXT]),
      .cw_o       (cw_q[i]),
      .ccw_o      (ccw_q[i]),
      .inj_valid_i(inj_valid_i[i]),
      .inj_ready_o(inj_ready_o[i]),
      .inj_dst_i  (inj_dst_i[i]),
      .inj_tag_i  (inj_tag_i[i]),
      .inj_data_i (inj_data_i[i]),
      .ej_valid_o (ej_valid_o[i]),
      .ej_ready_i (ej_ready_i[i]),
      .ej_src_o   (ej_src_o[i]),
      .ej_tag_o   (ej_tag_o[i]),
      .ej_data_o  (ej_data_o[i])
    );

    assign cw_vld[i]  = cw_q[i].vld;
    assign ccw_vld[i] = ccw_q[i].vld;
  end
endmodule

// File: rtl/bidir_ring_chk.sv
module bidir_ring_chk import ring_pkg::*; #(
  parameter int N_STOPS = 5
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [N_STOPS-1:0]             inj_valid_i,
  input logic [N_STOPS-1:0]             inj_ready_o,
  input logic [N_STOPS-1:0][STOP_W-1:0] inj_dst_i,
  input logic [N_STOPS-1:0]             ej_valid_o,
  input logic [N_STOPS-1:0]             ej_ready_i,
  input logic [N_STOPS-1:0]             cw_vld,
  input logic [N_STOPS-1:0]             ccw_vld
);
  localparam int H = N_STOPS - 1;

  function automatic bit goes_ccw(int s, logic [STOP_W-1:0] d);
    int h;
    h = (int'(d) + N_STOPS - s) % N_STOPS;
    return (2 * h) > N_STOPS;
  endfunction

  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;

  // R9
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen |-> (ej_valid_o == '0) && (inj_ready_o == '1));

  for (genvar i = 0; i < N_STOPS; i++) begin : g_chk
    localparam int PRV = (i + N_STOPS - 1) % N_STOPS;
    localparam int NXT = (i + 1) % N_STOPS;

    // R3
    free_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cw_vld[PRV] && !ccw_vld[NXT]) |-> inj_ready_o[i]);

    // R2
    inject_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inj_valid_i[i] && inj_ready_o[i]) |=> (cw_vld[i] || ccw_vld[i]));

    // R1
    cw_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inj_valid_i[i] && inj_ready_o[i] && !goes_ccw(i, inj_dst_i[i])) |=> cw_vld[i]);

    // R1
    ccw_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inj_valid_i[i] && inj_ready_o[i] && goes_ccw(i, inj_dst_i[i])) |=> ccw_vld[i]);

    // R7
    deflect_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ej_valid_o[i] && !ej_ready_i[i]) |=> (cw_vld[i] || ccw_vld[i]));
  end

  // R5
  host_lite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_vld[H-1] && ccw_vld[0]) |-> !inj_ready_o[H]);
endmodule

bind bidir_ring bidir_ring_chk #(.N_STOPS(N_STOPS)) u_chk (.*);

// File: tb/sim_bidir_ring.sv
module sim_bidir_ring;
  import ring_pkg::*;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]             inj_v, inj_r, ej_v, ej_r;
  logic [N-1:0][STOP_W-1:0] inj_dst, ej_src;
  logic [N-1:0][TAG_W-1:0]  inj_tag, ej_tag;
  logic [N-1:0][DATA_W-1:0] inj_dat, ej_dat;

  bidir_ring #(.N_STOPS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .inj_valid_i(inj_v), .inj_ready_o(inj_r), .inj_dst_i(inj_dst),
    .inj_tag_i(inj_tag), .inj_data_i(inj_dat),
    .ej_valid_o(ej_v), .ej_ready_i(ej_r), .ej_src_o(ej_src),
    .ej_tag_o(ej_tag), .ej_data_o(ej_dat)
  );

  typedef struct {
    bit v; int d; int s; int t; logic [DATA_W-1:0] dat;
  } mp_t;

  mp_t mcw [N];
  mp_t mccw[N];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int last_src[N], last_tag[N], last_cyc[N];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // compare one cycle against the model, then advance past the edge
  task automatic step();
    mp_t ncw[N];
    mp_t nccw[N];
    #1;
    for (int j = 0; j < N; j++) begin
      mp_t a, b, e;
      bit hc, hcc, tc, tcc, goccw, lite, fc, fcc, er;
      int hop;
      string rq;
      a = mcw[(j + N - 1) % N];
      b = mccw[(j + 1) % N];
      hc  = a.v && a.d == j;
      hcc = b.v && b.d == j;
      tc  = hc && ej_r[j];
      tcc = !hc && hcc && ej_r[j];
      hop = (int'(inj_dst[j]) + N - j) % N;
      goccw = 2 * hop > N;
      lite = (j == N - 1);
      fc  = !a.v || (!lite && tc);
      fcc = !b.v || (!lite && tcc);
      er  = goccw ? fcc : fc;
      rq = lite ? "R5" : ((goccw ? b.v : a.v) ? "R4" : "R3");
      chk(inj_r[j] === er, rq, "inj_ready", longint'(inj_r[j]), longint'(er));
      chk(ej_v[j] === (hc || hcc), "R2", "ej_valid", longint'(ej_v[j]), longint'(hc || hcc));
      if (hc || hcc) begin
        e = hc ? a : b;
        chk(int'(ej_src[j]) == e.s, "R8", "ej_src", longint'(ej_src[j]), longint'(e.s));
        chk(int'(ej_tag[j]) == e.t, "R8", "ej_tag", longint'(ej_tag[j]), longint'(e.t));
        chk(ej_dat[j] == e.dat, "R8", "ej_data", longint'(ej_dat[j]), longint'(e.dat));
      end
      if (ej_v[j] && ej_r[j]) begin
        last_src[j] = int'(ej_src[j]);
        last_tag[j] = int'(ej_tag[j]);
        last_cyc[j] = cyc;
      end
      ncw[j]  = tc  ? '{default: 0} : a;
      nccw[j] = tcc ? '{default: 0} : b;
      if (inj_v[j] && er) begin
        e = '{v: 1'b1, d: int'(inj_dst[j]), s: j, t: int'(inj_tag[j]), dat: inj_dat[j]};
        if (goccw) nccw[j] = e;
        else       ncw[j]  = e;
      end
    end
    mcw  = ncw;
    mccw = nccw;
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(int k);
    inj_v = '0;
    ej_r  = '1;
    repeat (k) step();
  endtask

  task automatic send(int s, int d, int t, logic [DATA_W-1:0] w);
    inj_v[s]   = 1'b1;
    inj_dst[s] = STOP_W'(d);
    inj_tag[s] = TAG_W'(t);
    inj_dat[s] = w;
    step();
    inj_v[s] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    for (int j = 0; j < N; j++) begin
      mcw[j] = '{default: 0};
      mccw[j] = '{default: 0};
      last_src[j] = -1; last_tag[j] = -1; last_cyc[j] = -1;
    end
    inj_v = '0; ej_r = '1; inj_dst = '0; inj_tag = '0; inj_dat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9
    chk(ej_v == '0, "R9", "ej_valid after reset", longint'(ej_v), 0);
    chk(inj_r == '1, "R9", "ready after reset", longint'(inj_r), 31);
    @(negedge clk);

    // R1: 0 -> 3 goes counter-clockwise, two hops
    c = cyc; send(0, 3, 5, 32'hA5A5_0003); idle(8);
    chk(last_cyc[3] == c + 2, "R1", "ccw arrival cycle", last_cyc[3], c + 2);
    chk(last_tag[3] == 5, "R8", "tag kept", last_tag[3], 5);

    // R2: 0 -> 2 clockwise, two hops; 1 -> 1 full lap
    c = cyc; send(0, 2, 6, 32'h0000_0102); idle(8);
    chk(last_cyc[2] == c + 2, "R2", "cw arrival cycle", last_cyc[2], c + 2);
    c = cyc; send(1, 1, 7, 32'h1111_1111); idle(8);
    chk(last_cyc[1] == c + 5, "R2", "self lap cycle", last_cyc[1], c + 5);

    // R6: both rings reach stop 2 together
    c = cyc;
    inj_v[0] = 1; inj_dst[0] = 2; inj_tag[0] = 1; inj_dat[0] = 32'hC0C0_0001;
    inj_v[4] = 1; inj_dst[4] = 2; inj_tag[4] = 2; inj_dat[4] = 32'hC0C0_0002;
    step(); inj_v = '0;
    idle(3);
    chk(last_cyc[2] == c + 2 && last_src[2] == 0, "R6", "cw wins src", last_src[2], 0);
    idle(6);
    chk(last_cyc[2] == c + 7 && last_src[2] == 4, "R6", "ccw lap cycle", last_cyc[2], c + 7);

    // R7: refused eject circulates back
    c = cyc; send(0, 3, 9, 32'h0000_0909); step();
    ej_r[3] = 1'b0; step(); ej_r[3] = 1'b1;
    idle(8);
    chk(last_cyc[3] == c + 7, "R7", "deflected return cycle", last_cyc[3], c + 7);

    // R4: full stop 2 reuses the slot freed by a leaving packet
    send(0, 2, 3, 32'h0000_0033); step();
    inj_v[2] = 1; inj_dst[2] = 3; inj_tag[2] = 4; inj_dat[2] = 32'h0000_0044;
    #1 chk(inj_r[2] === 1'b1, "R4", "reuse ready", longint'(inj_r[2]), 1);
    step(); inj_v[2] = 0; idle(6);

    // R5: host stop does not reuse the freed slot
    send(2, 4, 8, 32'h0000_0088); step();
    inj_v[4] = 1; inj_dst[4] = 0; inj_tag[4] = 10; inj_dat[4] = 32'h0000_00AA;
    #1 chk(inj_r[4] === 1'b0, "R5", "host blocked", longint'(inj_r[4]), 0);
    step();
    #1 chk(inj_r[4] === 1'b1, "R5", "host ready next", longint'(inj_r[4]), 1);
    step(); inj_v[4] = 0; idle(6);

    // mixed traffic with random eject back-pressure
    for (int k = 0; k < 3000; k++) begin
      for (int j = 0; j < N; j++) begin
        inj_v[j]   = ($urandom_range(0, 99) < 35);
        inj_dst[j] = STOP_W'($urandom_range(0, N - 1));
        inj_tag[j] = TAG_W'($urandom);
        inj_dat[j] = DATA_W'($urandom);
        ej_r[j]    = ($urandom_range(0, 99) < 80);
      end
      step();
    end
    idle(60);
    for (int j = 0; j < N; j++)
      chk(!mcw[j].v && !mccw[j].v && !ej_v[j], "R7", "drained", longint'(ej_v[j]), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule